// File: doc/BRIEF.md
# Side-Band Event to Notification Bridge

This block collects level-sensitive event lines from a fixed set of on-chip I/O devices and turns each newly fired event into one outbound notification. Every device owns a small register set: a message address, a message data word, a two-bit route field, an auxiliary data word and a sticky status field with one bit per event line. Software programs these fields over a simple synchronous register bus and clears status bits by writing ones.

The route field of a device decides where its events go. With the host bit set, the notification is a message-signalled-interrupt style memory write: the programmed address and data appear on the output port. With only the auxiliary bit set, the notification is a message to the auxiliary service unit that carries the device index and the auxiliary data word. With neither bit set, events are only recorded in status. When several devices have a notification waiting, a round-robin arbiter picks one per cycle for a single valid/ready output port.

Top module: `event_notify_bridge`

## Requirements
- R1: While reset is asserted and after it is released, out_valid is low, and every route field and status field reads back as zero.
- R2: A register write takes effect at the clock edge it is sampled on; reg_rdata shows the addressed field combinationally. The register address is {device index, select}, with the low three bits as select: 0 message address, 1 message data, 2 route (bit 0 host, bit 1 auxiliary), 3 auxiliary data, 4 status.
- R3: Event line k of device d is sb_in[d*LINES+k]. A rising edge on it sets status bit k of device d; the bit stays set whatever the line does afterwards and is cleared only by writing a 1 to that bit position of the status register.
- R4: With route bit 0 set, a new event produces one output item with out_dest=0, out_addr equal to the device's message address and out_data equal to its message data.
- R5: With route bit 0 clear and route bit 1 set, a new event produces one output item with out_dest=1, out_addr equal to the device index (zero-extended) and out_data equal to the auxiliary data word.
- R6: With both route bits clear, events set status but produce no output item.
- R7: An output item is produced only when a rising edge sets a status bit that was clear; an edge on a line whose status bit is already set produces nothing. After the bit is cleared, the next edge produces a new item.
- R8: Devices waiting at the same time are served round-robin: the search starts at the device after the last one served, and device 0 is first after reset.
- R9: While out_valid is high and out_ready is low, all output fields hold steady; with out_ready high, one item is accepted per cycle.
- R10: With both route bits set, the host destination wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sb_in | input | NUM_DEV*LINES | Side-band event levels, LINES per device |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | IW+3 | Register address {device, select} |
| reg_wdata | input | W | Register write data |
| reg_rdata | output | W | Read data of the addressed field |
| out_valid | output | 1 | Output item present |
| out_ready | input | 1 | Consumer accepts the item |
| out_dest | output | 1 | 0 host write, 1 auxiliary message |
| out_dev | output | IW | Index of the device served |
| out_addr | output | W | Write address, or device index for auxiliary messages |
| out_data | output | W | Message data or auxiliary data |

## Verification
Single events on a host-routed, an auxiliary-routed, an unrouted and a dual-routed device separate the four route decodings, including the check that auxiliary messages ignore the programmed message address. Repeated edges on an already-set line, an edge on a second line of the same device and an edge after a write-one clear tell the new-bit rule apart from plain edge counting. Simultaneous events with the consumer stalled show that the output holds, and a pair of devices fired after a single serve of a middle device shows round-robin order rather than fixed priority.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  typedef enum logic [2:0] {
    SEL_MADDR = 3'd0,
    SEL_MDATA = 3'd1,
    SEL_ROUTE = 3'd2,
    SEL_AUX   = 3'd3,
    SEL_STAT  = 3'd4
  } reg_sel_e;

  localparam int ROUTE_HOST = 0;
  localparam int ROUTE_AUX  = 1;
endpackage

// File: rtl/bridge_dev_slot.sv
module bridge_dev_slot
  import bridge_pkg::*;
#(
  parameter int LINES = 2,
  parameter int W     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] sb_lvl,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [W-1:0]     wr_data,
  input  logic             grant,
  output logic [W-1:0]     msi_addr,
  output logic [W-1:0]     msi_data,
  output logic [1:0]       route,
  output logic [W-1:0]     aux_data,
  output logic [LINES-1:0] status,
  output logic             pend
);
  logic [LINES-1:0] sb_prev_q, status_q, status_nxt, rise, clr;
  logic [W-1:0]     maddr_q, mdata_q, aux_q;
  logic [1:0]       route_q;
  logic             pend_q, pend_nxt, routed, fresh;

  always_comb begin
    rise       = sb_lvl & ~sb_prev_q;
    clr        = (wr_en && wr_sel == SEL_STAT) ? wr_data[LINES-1:0] : '0;
    status_nxt = (status_q & ~clr) | rise;
    routed     = |route_q;
    fresh      = |(rise & ~status_q);
    pend_nxt   = pend_q;
    if (grant || !routed) pend_nxt = 1'b0;
    if (fresh && routed)  pend_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sb_prev_q <= '0;
      status_q  <= '0;
      pend_q    <= 1'b0;
    end else begin
      sb_prev_q <= sb_lvl;
      status_q  <= status_nxt;
      pend_q    <= pend_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maddr_q <= '0;
      mdata_q <= '0;
      route_q <= '0;
      aux_q   <= '0;
    end else begin
      if (wr_en && wr_sel == SEL_MADDR) maddr_q <= wr_data;
      if (wr_en && wr_sel == SEL_MDATA) mdata_q <= wr_data;
      if (wr_en && wr_sel == SEL_ROUTE) route_q <= wr_data[1:0];
      if (wr_en && wr_sel == SEL_AUX)   aux_q   <= wr_data;
    end
  end

  assign msi_addr = maddr_q;
  assign msi_data = mdata_q;
  assign route    = route_q;
  assign aux_data = aux_q;
  assign status   = status_q;
  assign pend     = pend_q;
endmodule

// File: rtl/bridge_rr_arb.sv
module bridge_rr_arb #(
  parameter  int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          any
);
  logic [IW-1:0] ptr_q, ptr_nxt;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    any     = 1'b0;
    for (int off = 1; off <= N; off++) begin
      int c;
      c = (int'(ptr_q) + off) % N;
      if (!any && req[c]) begin
        any     = 1'b1;
        gnt[c]  = 1'b1;
        gnt_idx = IW'(c);
      end
    end
    ptr_nxt = (adv && any) ? gnt_idx : ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= IW'(N - 1);
    else        ptr_q <= ptr_nxt;
  end
endmodule

// File: rtl/event_notify_bridge.sv
module event_notify_bridge
  import bridge_pkg::*;
#(
  parameter  int NUM_DEV = 4,
  parameter  int LINES   = 2,
  parameter  int W       = 32,
  localparam int IW      = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  localparam int RA_W    = IW + 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_DEV*LINES-1:0] sb_in,
  input  logic                     reg_we,
  input  logic [RA_W-1:0]          reg_addr,
  input  logic [W-1:0]             reg_wdata,
  output logic [W-1:0]             reg_rdata,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic                     out_dest,
  output logic [IW-1:0]            out_dev,
  output logic [W-1:0]             out_addr,
  output logic [W-1:0]             out_data
);
  logic [IW-1:0]    sel_dev;
  logic [2:0]       sel_reg;
  logic [W-1:0]     maddr_a [NUM_DEV];
  logic [W-1:0]     mdata_a [NUM_DEV];
  logic [W-1:0]     aux_a   [NUM_DEV];
  logic [1:0]       route_a [NUM_DEV];
  logic [LINES-1:0] stat_a  [NUM_DEV];
  logic [NUM_DEV-1:0] pend_vec, gnt, gnt_live;
  logic [IW-1:0]    gnt_idx;
  logic             any, can_load;

  logic             valid_q, valid_nxt, dest_q, dest_nxt;
  logic [IW-1:0]    dev_q, dev_nxt;
  logic [W-1:0]     addr_q, addr_nxt, data_q, data_nxt;

  assign sel_dev = reg_addr[RA_W-1:3];
  assign sel_reg = reg_addr[2:0];

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    bridge_dev_slot #(.LINES(LINES), .W(W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .sb_lvl   (sb_in[d*LINES +: LINES]),
      .wr_en    (reg_we && (sel_dev == IW'(d))),
      .wr_sel   (sel_reg),
      .wr_data  (reg_wdata),
      .grant    (gnt_live[d]),
      .msi_addr (maddr_a[d]),
      .msi_data (mdata_a[d]),
      .route    (route_a[d]),
      .aux_data (aux_a[d]),
      .status   (stat_a[d]),
      .pend     (pend_vec[d])
    );
  end

  bridge_rr_arb #(.N(NUM_DEV)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (pend_vec),
    .adv     (can_load),
    .gnt     (gnt),
    .gnt_idx (gnt_idx),
    .any     (any)
  );

  assign can_load = !valid_q || out_ready;
  assign gnt_live = gnt & {NUM_DEV{can_load}};

  always_comb begin
    reg_rdata = '0;
    if (int'(sel_dev) < NUM_DEV) begin
      case (sel_reg)
        SEL_MADDR: reg_rdata = maddr_a[sel_dev];
        SEL_MDATA: reg_rdata = mdata_a[sel_dev];
        SEL_ROUTE: reg_rdata[1:0] = route_a[sel_dev];
        SEL_AUX:   reg_rdata = aux_a[sel_dev];
        SEL_STAT:  reg_rdata[LINES-1:0] = stat_a[sel_dev];
        default:   reg_rdata = '0;
      endcase
    end
  end

  always_comb begin
    valid_nxt = any;
    dev_nxt   = gnt_idx;
    dest_nxt  = !route_a[gnt_idx][ROUTE_HOST];
    addr_nxt  = dest_nxt ? W'(gnt_idx)      : maddr_a[gnt_idx];
    data_nxt  = dest_nxt ? aux_a[gnt_idx]   : mdata_a[gnt_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      dest_q  <= 1'b0;
      dev_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (can_load) begin
      valid_q <= valid_nxt;
      if (any) begin
        dest_q <= dest_nxt;
        dev_q  <= dev_nxt;
        addr_q <= addr_nxt;
        data_q <= data_nxt;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_dest  = dest_q;
  assign out_dev   = dev_q;
  assign out_addr  = addr_q;
  assign out_data  = data_q;
endmodule

// File: rtl/bridge_checker.sv
module bridge_checker #(
  parameter  int NUM_DEV = 4,
  parameter  int W       = 32,
  localparam int IW      = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               out_valid,
  input logic               out_ready,
  input logic               out_dest,
  input logic [IW-1:0]      out_dev,
  input logic [W-1:0]       out_addr,
  input logic [W-1:0]       out_data,
  input logic [NUM_DEV-1:0] gnt_live,
  input logic [NUM_DEV-1:0] pend
);
  AST_IDLE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid); // R1

  AST_AUX_CARRIES_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_dest) |-> (out_addr == W'(out_dev))); // R5

  AST_GRANT_FROM_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt_live) |-> (|(gnt_live & pend))); // R7

  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_live)); // R8

  AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_dest) && $stable(out_dev)
                                   && $stable(out_addr) && $stable(out_data))); // R9

  AST_GRANT_FILLS_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt_live) |=> out_valid); // R9
endmodule

bind event_notify_bridge bridge_checker #(.NUM_DEV(NUM_DEV), .W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_dest  (out_dest),
  .out_dev   (out_dev),
  .out_addr  (out_addr),
  .out_data  (out_data),
  .gnt_live  (gnt_live),
  .pend      (pend_vec)
);

// File: tb/tb_event_notify_bridge.sv
module tb_event_notify_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int NDEV = 4;
  localparam int NL   = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NDEV*NL-1:0] sb_in;
  logic            reg_we;
  logic [4:0]      reg_addr;
  logic [31:0]     reg_wdata, reg_rdata;
  logic            out_valid, out_ready, out_dest;
  logic [1:0]      out_dev;
  logic [31:0]     out_addr, out_data;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    bit          dest;
    int          dev;
    logic [31:0] a;
    logic [31:0] d;
    string       req;
  } msg_t;
  msg_t expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  event_notify_bridge #(.NUM_DEV(NDEV), .LINES(NL), .W(32)) dut (
    .clk(clk), .rst_n(rst_n), .sb_in(sb_in), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .out_valid(out_valid),
    .out_ready(out_ready), .out_dest(out_dest), .out_dev(out_dev),
    .out_addr(out_addr), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input int dev, input int sel, input logic [31:0] v);
    reg_addr = {dev[1:0], sel[2:0]}; reg_wdata = v; reg_we = 1'b1;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd_check(input int dev, input int sel, input logic [31:0] exp, input string req);
    reg_addr = {dev[1:0], sel[2:0]};
    #1;
    check(reg_rdata == exp, req, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic expect_msg(input bit dest, input int dev, input logic [31:0] a,
                            input logic [31:0] d, input string req);
    msg_t m;
    m.dest = dest; m.dev = dev; m.a = a; m.d = d; m.req = req;
    expq.push_back(m);
  endtask

  task automatic pulse(input int dev, input int line);
    sb_in[dev*NL+line] = 1'b1;
    tick();
    sb_in[dev*NL+line] = 1'b0;
    tick();
  endtask

  task automatic quiet(input int n, input string req);
    repeat (n) tick();
    check(expq.size() == 0, req, 64'(expq.size()), 64'd0);
  endtask

  task automatic clear_all();
    for (int d = 0; d < NDEV; d++) wr(d, 4, 32'hFFFF_FFFF);
  endtask

  // Monitor: acceptance happens at the next rising edge, so inputs and outputs
  // sampled at the falling edge predict it exactly.
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (expq.size() == 0) begin
        check(1'b0, "R6/R7 unexpected item", {31'd0, out_dest, 30'd0, out_dev}, 64'd0);
      end else begin
        msg_t m;
        m = expq.pop_front();
        check(out_dest == m.dest && int'(out_dev) == m.dev, m.req,
              {31'd0, out_dest, 30'd0, out_dev}, {31'd0, m.dest, m.dev});
        check(out_addr == m.a && out_data == m.d, m.req,
              {out_addr, out_data}, {m.a, m.d});
      end
    end
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] held_a;
    rst_n = 1'b0; sb_in = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; out_ready = 1'b1;
    repeat (3) tick();
    check(out_valid == 1'b0, "R1 valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    tick();
    check(out_valid == 1'b0, "R1 valid after reset", 64'(out_valid), 64'd0);
    rd_check(0, 2, 32'd0, "R1 route");
    rd_check(3, 4, 32'd0, "R1 status");

    // Programming
    wr(0, 0, 32'h1000_0040); wr(0, 1, 32'h0000_00A5); wr(0, 2, 32'd1);
    wr(1, 0, 32'hDEAD_0000); wr(1, 3, 32'h0000_BEEF); wr(1, 2, 32'd2);
    wr(2, 2, 32'd0);
    wr(3, 0, 32'h2000_0080); wr(3, 1, 32'h0000_0033); wr(3, 3, 32'h0000_0077); wr(3, 2, 32'd3);
    rd_check(0, 0, 32'h1000_0040, "R2 msg address");
    rd_check(1, 3, 32'h0000_BEEF, "R2 aux data");
    rd_check(3, 2, 32'd3, "R2 route");

    // Host route, new-bit rule
    expect_msg(1'b0, 0, 32'h1000_0040, 32'hA5, "R4 host write");
    pulse(0, 0);
    quiet(3, "R4 drained");
    rd_check(0, 4, 32'd1, "R3 status sticky");
    pulse(0, 0);
    quiet(4, "R7 re-edge on set bit");
    expect_msg(1'b0, 0, 32'h1000_0040, 32'hA5, "R7 second line");
    pulse(0, 1);
    quiet(3, "R7 drained");
    rd_check(0, 4, 32'd3, "R3 two bits");
    wr(0, 4, 32'd1);
    rd_check(0, 4, 32'd2, "R3 write-one clear");
    expect_msg(1'b0, 0, 32'h1000_0040, 32'hA5, "R7 after clear");
    pulse(0, 0);
    quiet(3, "R7 drained after clear");

    // Aux, unrouted, dual route
    expect_msg(1'b1, 1, 32'd1, 32'h0000_BEEF, "R5 aux message");
    pulse(1, 0);
    quiet(3, "R5 drained");
    pulse(2, 1);
    quiet(4, "R6 no item");
    rd_check(2, 4, 32'd2, "R6 status set");
    expect_msg(1'b0, 3, 32'h2000_0080, 32'h33, "R10 host wins");
    pulse(3, 0);
    quiet(3, "R10 drained");
    clear_all();

    // Stall with three devices pending; last served was device 3
    out_ready = 1'b0;
    expect_msg(1'b0, 0, 32'h1000_0040, 32'hA5, "R8 order first");
    expect_msg(1'b1, 1, 32'd1, 32'h0000_BEEF, "R8 order second");
    expect_msg(1'b0, 3, 32'h2000_0080, 32'h33, "R8 order third");
    sb_in[0] = 1'b1; sb_in[2] = 1'b1; sb_in[6] = 1'b1;
    tick(); tick();
    check(out_valid == 1'b1, "R9 item waiting", 64'(out_valid), 64'd1);
    held_a = out_addr;
    repeat (3) tick();
    check(out_valid == 1'b1 && out_addr == held_a, "R9 held while stalled",
          64'(out_addr), 64'(held_a));
    out_ready = 1'b1;
    quiet(5, "R9 drained");
    sb_in = '0;
    tick();
    clear_all();

    // Serve device 1 alone, then fire 0 and 3 together: 3 comes first
    expect_msg(1'b1, 1, 32'd1, 32'h0000_BEEF, "R8 single serve");
    pulse(1, 1);
    quiet(3, "R8 single drained");
    clear_all();
    expect_msg(1'b0, 3, 32'h2000_0080, 32'h33, "R8 rotation first");
    expect_msg(1'b0, 0, 32'h1000_0040, 32'hA5, "R8 rotation second");
    sb_in[1] = 1'b1; sb_in[7] = 1'b1;
    tick();
    sb_in = '0;
    quiet(5, "R8 rotation drained");

    summary();
    $finish;
  end
endmodule